// File: doc/BRIEF.md
# Debug Port Unlock Gate

This block guards an on-chip debug port. A ten-byte reference ID, taken from a fixed region of non-volatile memory (offsets 0x70 to 0x79 of the internal ROM), is held on `refId`. At connection time the debugger presents its own ten-byte ID one byte per strobe. The debug port unlocks only when all 80 bits agree. Until then, every debug read of CPU registers, special function registers or memory is refused. A refused read returns zero and raises a one-cycle error flag.

An erased device holds 0xFF in every ID byte, so ten 0xFF bytes open an unprogrammed part. Bit 7 of the reference byte at offset 9 (address 0x79) works as a kill switch. When it is programmed to 0, the block reports itself permanently disabled and refuses to unlock, even when the ID matches. The unlocked state lasts until device reset, and each reset requires a fresh ten-byte presentation.

Top module: `dbg_id_gate`

## Requirements
- R1: While `rstN` is low, `unlocked`, `accessEn`, `permDisabled`, `accessErr` and `rdDataOut` are all 0.
- R2: Presented bytes fill slots 0 to 9 in arrival order, with slot i compared against `refId[8*i+7:8*i]` (lowest address first). On the strobe of the tenth byte, a full match sets `unlocked` and `accessEn` at that clock edge. Before the tenth byte they stay 0, and the same bytes presented in reverse order do not unlock.
- R3: With every reference byte equal to 0xFF (erased), ten 0xFF bytes unlock the port.
- R4: A difference in any single one of the 80 bits leaves the port locked; there is no partial unlock.
- R5: After a failed ten-byte attempt the slot counter restarts at slot 0, so the next ten bytes form a complete new attempt.
- R6: While locked, a read request (`rdReq` high at an edge) yields `rdDataOut` = 0 and `accessErr` = 1 after that edge, for one cycle only.
- R7: While unlocked, a read request yields `rdDataOut` equal to the `rdDataIn` sampled with the request, with `accessErr` = 0.
- R8: When bit 79 of `refId` (bit 7 of byte 9) is 0, `permDisabled` is 1 from the first edge after reset. The port never unlocks, even on an exact ID match, and `permDisabled` stays set until reset.
- R9: Once unlocked, the port stays unlocked and further ID strobes are ignored. Only reset clears it, and after reset a new full presentation is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous device reset |
| refId | input | 80 | Reference ID, byte i at bits 8i+7:8i |
| idByte | input | 8 | Presented ID byte |
| idStrobe | input | 1 | Accepts `idByte` into the next slot |
| rdReq | input | 1 | Debug read request |
| rdDataIn | input | 32 | Data from the addressed debug resource |
| rdDataOut | output | 32 | Gated read data returned to the debugger |
| accessErr | output | 1 | One-cycle flag for a refused read |
| unlocked | output | 1 | Port unlocked |
| permDisabled | output | 1 | Port permanently disabled by the kill bit |
| accessEn | output | 1 | Access enable toward debug resources |

## Verification
The unlock result is due one edge after the tenth strobe. The bench drives each byte at a falling edge and samples `unlocked` at the next falling edge, so the flag is read exactly one cycle after the deciding byte. Read results (`rdDataOut`, `accessErr`) are due one edge after the request. They are checked at the following falling edge, and the falling edge after that confirms the error flag has cleared. `permDisabled` is sampled one edge after reset is released, which is the first cycle in which it is defined.

// File: rtl/dbg_id_gate_pkg.sv
package dbg_id_gate_pkg;
  parameter int ID_BYTES = 10;
  parameter int BYTE_W   = 8;
  localparam int ID_W    = ID_BYTES * BYTE_W;
  localparam int IDX_W   = $clog2(ID_BYTES);
  localparam int KILL_BIT = ID_W - 1;

  typedef struct packed {
    logic             capture;
    logic             finalByte;
    logic [IDX_W-1:0] slot;
    logic             grant;
  } ctrlStrobes_t;
endpackage

// File: rtl/dbg_id_ctrl.sv
module dbg_id_ctrl
  import dbg_id_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         idStrobe,
  input  logic         matchNow,
  input  logic         refDisBit,
  output ctrlStrobes_t strb,
  output logic         unlocked,
  output logic         permDisabled
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(ID_BYTES - 1);

  logic [IDX_W-1:0] slotCnt;

  always_comb begin
    strb.capture   = idStrobe && !unlocked && !permDisabled && refDisBit;
    strb.slot      = slotCnt;
    strb.finalByte = strb.capture && (slotCnt == LAST_SLOT);
    strb.grant     = unlocked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt      <= '0;
      unlocked     <= 1'b0;
      permDisabled <= 1'b0;
    end else begin
      if (!refDisBit) permDisabled <= 1'b1;
      if (strb.capture) begin
        if (strb.finalByte) begin
          slotCnt <= '0;
          if (matchNow) unlocked <= 1'b1;
        end else begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
    end
  end

  // R9
  unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    unlocked |=> unlocked);

  // R2
  unlock_on_final_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(strb.finalByte && matchNow));

  // R8
  no_unlock_killed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(refDisBit));

  // R8
  kill_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    permDisabled |=> permDisabled);
endmodule

// File: rtl/dbg_id_datapath.sv
module dbg_id_datapath
  import dbg_id_gate_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [BYTE_W-1:0] idByte,
  input  logic [ID_W-1:0]   refId,
  input  logic              rdReq,
  input  logic [DATA_W-1:0] rdDataIn,
  output logic              matchNow,
  output logic [DATA_W-1:0] rdDataOut,
  output logic              accessErr
);
  localparam int HELD_N = ID_BYTES - 1;

  logic [BYTE_W-1:0] heldByte [HELD_N];
  logic [ID_BYTES-1:0] byteEq;

  for (genvar i = 0; i < HELD_N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) heldByte[i] <= '0;
      else if (strb.capture && strb.slot == IDX_W'(i)) heldByte[i] <= idByte;
    end
    assign byteEq[i] = (heldByte[i] == refId[i*BYTE_W +: BYTE_W]);
  end

  assign byteEq[HELD_N] = (idByte == refId[HELD_N*BYTE_W +: BYTE_W]);
  assign matchNow = &byteEq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataOut <= '0;
      accessErr <= 1'b0;
    end else if (rdReq && strb.grant) begin
      rdDataOut <= rdDataIn;
      accessErr <= 1'b0;
    end else begin
      rdDataOut <= '0;
      accessErr <= rdReq;
    end
  end

  // R6
  locked_read_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !strb.grant) |=> (accessErr && rdDataOut == '0));

  // R7
  open_read_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && strb.grant) |=> (!accessErr && rdDataOut == $past(rdDataIn)));

  // R6
  err_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> $past(rdReq));
endmodule

// File: rtl/dbg_id_gate.sv
module dbg_id_gate
  import dbg_id_gate_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   refId,
  input  logic [BYTE_W-1:0] idByte,
  input  logic              idStrobe,
  input  logic              rdReq,
  input  logic [DATA_W-1:0] rdDataIn,
  output logic [DATA_W-1:0] rdDataOut,
  output logic              accessErr,
  output logic              unlocked,
  output logic              permDisabled,
  output logic              accessEn
);
  ctrlStrobes_t strb;
  logic matchNow;

  dbg_id_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .idStrobe(idStrobe), .matchNow(matchNow),
    .refDisBit(refId[KILL_BIT]), .strb(strb), .unlocked(unlocked),
    .permDisabled(permDisabled)
  );

  dbg_id_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idByte(idByte), .refId(refId),
    .rdReq(rdReq), .rdDataIn(rdDataIn), .matchNow(matchNow),
    .rdDataOut(rdDataOut), .accessErr(accessErr)
  );

  assign accessEn = unlocked;

  // R1
  reset_closed_chk: assert property (@(posedge clk)
    !rstN |=> (!unlocked && !accessEn && !accessErr));
endmodule

// File: tb/dbg_id_gate_bench.sv
`timescale 1ns/1ps
module dbg_id_gate_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [79:0] refId = '1;
  logic [7:0]  idByte = '0;
  logic        idStrobe = 1'b0;
  logic        rdReq = 1'b0;
  logic [31:0] rdDataIn = '0;
  logic [31:0] rdDataOut;
  logic        accessErr, unlocked, permDisabled, accessEn;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dbg_id_gate u_dbg_id_gate (
    .clk(clk), .rstN(rstN), .refId(refId), .idByte(idByte), .idStrobe(idStrobe),
    .rdReq(rdReq), .rdDataIn(rdDataIn), .rdDataOut(rdDataOut),
    .accessErr(accessErr), .unlocked(unlocked), .permDisabled(permDisabled),
    .accessEn(accessEn)
  );

  localparam logic [79:0] KEY  = 80'hF1_23_45_67_89_AB_CD_EF_10_32;
  localparam logic [79:0] REV  = 80'h32_10_EF_CD_AB_89_67_45_23_F1;
  localparam logic [79:0] KILL = 80'h71_23_45_67_89_AB_CD_EF_10_32;
  localparam logic [79:0] ONES = '1;

  // {reference, presented, expected unlock}
  localparam logic [160:0] VEC [7] = '{
    {ONES, ONES, 1'b1},                    // R3 erased part
    {KEY,  KEY,  1'b1},                    // R2 exact match
    {KEY,  KEY ^ 80'h1, 1'b0},             // R4 lowest bit
    {KEY,  KEY ^ (80'h1 << 78), 1'b0},     // R4 high bit
    {ONES, KEY,  1'b0},                    // R4 many bits
    {KILL, KILL, 1'b0},                    // R8 kill bit clear
    {KEY,  REV,  1'b0}                     // R2 byte order
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [79:0] r);
    @(negedge clk);
    rstN = 1'b0; refId = r;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    idByte = b; idStrobe = 1'b1;
    @(negedge clk);
    idStrobe = 1'b0;
  endtask

  task automatic sendId(input logic [79:0] id);
    for (int i = 0; i < 10; i++) sendByte(id[i*8 +: 8]);
  endtask

  task automatic doRead(input string req, input logic [31:0] d, input logic open);
    rdReq = 1'b1; rdDataIn = d;
    @(negedge clk);
    rdReq = 1'b0; rdDataIn = 32'h0;
    chk(req, rdDataOut, open ? d : 32'h0);
    chk(req, {31'h0, accessErr}, {31'h0, !open});
    @(negedge clk);
    chk(req, {31'h0, accessErr}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    rstN = 1'b0; refId = KEY;
    repeat (2) @(negedge clk);
    chk("R1", {28'h0, unlocked, accessEn, permDisabled, accessErr}, 32'h0);
    chk("R1", rdDataOut, 32'h0);

    foreach (VEC[v]) begin
      doReset(VEC[v][160:81]);
      chk("R8", {31'h0, permDisabled}, {31'h0, !VEC[v][160]});
      sendId(VEC[v][80:1]);
      chk(VEC[v][0] ? "R2/R3" : "R4/R8", {31'h0, unlocked}, {31'h0, VEC[v][0]});
      chk("R2", {31'h0, accessEn}, {31'h0, VEC[v][0]});
      doRead(VEC[v][0] ? "R7" : "R6", 32'hC0DE_0000 + v, VEC[v][0]);
    end

    // R2 nine bytes are not enough
    doReset(KEY);
    for (int i = 0; i < 9; i++) sendByte(KEY[i*8 +: 8]);
    chk("R2", {31'h0, unlocked}, 32'h0);
    sendByte(KEY[79:72]);
    chk("R2", {31'h0, unlocked}, 32'h1);

    // R5 failed attempt then fresh attempt
    doReset(KEY);
    sendId(KEY ^ (80'h1 << 40));
    chk("R5", {31'h0, unlocked}, 32'h0);
    sendId(KEY);
    chk("R5", {31'h0, unlocked}, 32'h1);

    // R9 sticky, strobes ignored, reset clears
    sendId(80'h0);
    chk("R9", {31'h0, unlocked}, 32'h1);
    doRead("R9", 32'hA5A5_5A5A, 1'b1);
    doReset(KEY);
    chk("R9", {31'h0, unlocked}, 32'h0);
    doRead("R9", 32'h1234_5678, 1'b0);

    // R8 kill bit holds across attempts
    doReset(KILL);
    sendId(KILL);
    sendId(KILL);
    chk("R8", {30'h0, permDisabled, unlocked}, 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule